// File: doc/BRIEF.md
# Two-Channel Instruction Breakpoint Unit

This block sits beside a CPU and watches every bus cycle it issues. Two comparison channels, A and B, each hold a compare address, an address mask, an optional address-space identifier (ASID) and a cycle qualifier. When the programmed conditions are met, the block raises a one-cycle break request toward the exception logic. The qualifier selects fetch or data access, read or write, and operand size. Channel B also compares the bus data under a data mask.

The channels run in one of two modes. In the independent mode either channel raises the break on its own. In the sequence mode a channel B match raises the break only once channel A has matched. For instruction fetches, each channel chooses whether the break is taken before the matched instruction runs or after it retires. The CPU marks retirement with a one-cycle pulse. Configuration comes through a small write-only register port. A sticky status bit per channel records that its condition was seen.

Top module: `brk_unit`

## Requirements
- R1: An address matches a channel when it equals the compare address in every bit whose mask bit is 0; bits whose mask bit is 1 are don't-care (base 0x8010, mask 0x0006 accepts 0x8010, 0x8012, 0x8014 and 0x8016 but not 0x8011 or 0x8018).
- R2: With mode bit 0 clear (independent), a qualifying match on either channel raises `brk_req` on its own.
- R3: With mode bit 0 set (sequence), a channel A match raises no break and arms the unit. A channel B match raises the break only while armed, and the break disarms the unit.
- R4: Writing the mode register or either control register disarms the unit.
- R5: The control-word bit 7 is the after-execution bit. A fetch match with bit 7 clear raises `brk_req` together with `brk_before`=1 on the clock edge after the fetch. With bit 7 set, the match is held and the break, with `brk_before`=0, is raised on the edge after the next `ret_valid` pulse. That pulse consumes the held match.
- R6: With control bit 8 set, a channel matches only when `bus_asid` equals control bits 31:24. With bit 8 clear, the ASID is ignored.
- R7: Control bits 6:4 select the size: 0 means any size, 1 byte, 2 word and 3 long. These are compared against `bus_size`, where 0 is byte, 1 word and 2 long.
- R8: When channel B has control bit 9 set, its data must match the data-value register in every bit where the data mask is 0. When bit 9 is clear, bus data has no effect.
- R9: Control bit 0 enables fetch cycles. Bit 1 enables data cycles, and for data cycles bit 2 enables reads and bit 3 enables writes. A cycle with `bus_valid` low never matches, and a channel with bits 0 and 1 both clear never matches.
- R10: `brk_req` is a registered pulse of one cycle per break event, and `brk_before` is high only together with `brk_req`.
- R11: `stat_a` and `stat_b` go high on the edge after their channel's condition matches, in either mode, and stay high. A mode-register write with bit 1 (for A) or bit 2 (for B) at 0 clears them, and a new match in the same cycle wins.
- R12: The register indices on `cfg_addr` are 0, 1 and 2 for channel A's address, mask and control, and 3, 4 and 5 for the same three on channel B. Index 6 is channel B's data value, 7 its data mask and 8 the mode register. Synchronous reset zeroes every register, the held matches, the arm flag and all outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register index |
| cfg_wdata | input | 32 | Register write data |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_ifetch | input | 1 | 1 instruction fetch, 0 data access |
| bus_write | input | 1 | 1 write, 0 read (data cycles) |
| bus_size | input | 2 | Operand size: 0 byte, 1 word, 2 long |
| bus_addr | input | AW | Bus address |
| bus_data | input | DW | Bus data |
| bus_asid | input | 8 | Current address-space identifier |
| ret_valid | input | 1 | Pulse: the fetched instruction retires |
| brk_req | output | 1 | Break request pulse |
| brk_before | output | 1 | Break is taken before the instruction executes |
| stat_a | output | 1 | Sticky channel A match status |
| stat_b | output | 1 | Sticky channel B match status |

## Verification
The properties assume that reset is held for at least two clock edges, so the control registers are known zero before any history is used. They also assume that `ret_valid` refers to the most recently fetched instruction that is still outstanding. The stimulus holds reset for several cycles. It issues at most one bus cycle per clock and one retire pulse per held match, and it separates every stimulus cycle with an idle one. Register writes never coincide with bus cycles, except where a rewrite is meant to disarm the sequence.

// File: rtl/brk_pkg.sv
package brk_pkg;

  localparam int NCH    = 2;
  localparam int ASID_W = 8;
  localparam int CFG_W  = 32;
  localparam int RA_W   = 4;

  typedef enum logic [RA_W-1:0] {
    RG_A_ADDR  = 4'd0,
    RG_A_MASK  = 4'd1,
    RG_A_CTRL  = 4'd2,
    RG_B_ADDR  = 4'd3,
    RG_B_MASK  = 4'd4,
    RG_B_CTRL  = 4'd5,
    RG_B_DATA  = 4'd6,
    RG_B_DMASK = 4'd7,
    RG_MODE    = 4'd8
  } brk_reg_e;

  localparam int REGS_PER_CH = 3;

  typedef struct packed {
    logic [ASID_W-1:0] asid;     // 31:24
    logic [13:0]       rsv;      // 23:10
    logic              data_en;  // 9
    logic              asid_en;  // 8
    logic              after;    // 7
    logic [2:0]        size;     // 6:4
    logic              en_wr;    // 3
    logic              en_rd;    // 2
    logic              en_data;  // 1
    logic              en_fetch; // 0
  } brk_ctrl_t;

  localparam int MODE_SEQ_BIT  = 0;
  localparam int MODE_KEEP_LSB = 1;

  function automatic logic size_ok(input logic [2:0] sel, input logic [1:0] sz);
    return (sel == 3'd0) || (sel == ({1'b0, sz} + 3'd1));
  endfunction

endpackage

// File: rtl/brk_cfg_regs.sv
module brk_cfg_regs
  import brk_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [RA_W-1:0]           waddr,
  input  logic [CFG_W-1:0]          wdata,
  input  logic [NCH-1:0]            hit,
  output logic [NCH-1:0][AW-1:0]    cmp_addr,
  output logic [NCH-1:0][AW-1:0]    cmp_mask,
  output brk_ctrl_t [NCH-1:0]       ctrl,
  output logic [DW-1:0]             dval,
  output logic [DW-1:0]             dmask,
  output logic                      seq_mode,
  output logic [NCH-1:0]            stat,
  output logic [NCH-1:0]            ctrl_wr,
  output logic                      arm_clr
);

  logic mode_we;
  assign mode_we = we && (waddr == RG_MODE);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam logic [RA_W-1:0] BASE = RA_W'(ch * REGS_PER_CH);
    logic wr_addr, wr_mask, wr_ctrl;
    assign wr_addr = we && (waddr == BASE);
    assign wr_mask = we && (waddr == BASE + 4'd1);
    assign wr_ctrl = we && (waddr == BASE + 4'd2);
    assign ctrl_wr[ch] = wr_ctrl;

    always_ff @(posedge clk) begin
      if (rst) begin
        cmp_addr[ch] <= '0;
        cmp_mask[ch] <= '0;
        ctrl[ch]     <= '0;
        stat[ch]     <= 1'b0;
      end else begin
        if (wr_addr) cmp_addr[ch] <= wdata[AW-1:0];
        if (wr_mask) cmp_mask[ch] <= wdata[AW-1:0];
        if (wr_ctrl) ctrl[ch]     <= brk_ctrl_t'(wdata);
        if (hit[ch])
          stat[ch] <= 1'b1;
        else if (mode_we && !wdata[MODE_KEEP_LSB + ch])
          stat[ch] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dval     <= '0;
      dmask    <= '0;
      seq_mode <= 1'b0;
    end else begin
      if (we && waddr == RG_B_DATA)  dval  <= wdata[DW-1:0];
      if (we && waddr == RG_B_DMASK) dmask <= wdata[DW-1:0];
      if (mode_we) seq_mode <= wdata[MODE_SEQ_BIT];
    end
  end

  assign arm_clr = mode_we || (|ctrl_wr);

endmodule

// File: rtl/brk_channel.sv
module brk_channel
  import brk_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter bit HAS_DATA = 1'b0
) (
  input  logic              bus_valid,
  input  logic              bus_ifetch,
  input  logic              bus_write,
  input  logic [1:0]        bus_size,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_data,
  input  logic [ASID_W-1:0] bus_asid,
  input  logic [AW-1:0]     cmp_addr,
  input  logic [AW-1:0]     cmp_mask,
  input  brk_ctrl_t         ctrl,
  input  logic [DW-1:0]     dval,
  input  logic [DW-1:0]     dmask,
  output logic              hit,
  output logic              imm,
  output logic              defer,
  output logic              bef
);

  logic kind_ok, addr_ok, asid_ok, sz_ok, data_ok;

  assign kind_ok = bus_ifetch ? ctrl.en_fetch
                              : (ctrl.en_data && (bus_write ? ctrl.en_wr : ctrl.en_rd));
  assign addr_ok = ((bus_addr ^ cmp_addr) & ~cmp_mask) == '0;
  assign asid_ok = !ctrl.asid_en || (bus_asid == ctrl.asid);
  assign sz_ok   = size_ok(ctrl.size, bus_size);

  if (HAS_DATA) begin : g_data
    assign data_ok = !ctrl.data_en || (((bus_data ^ dval) & ~dmask) == '0);
  end else begin : g_nodata
    logic unused_data;
    assign unused_data = ^{dval, dmask, bus_data, ctrl.data_en};
    assign data_ok = 1'b1;
  end

  logic unused_rsv;
  assign unused_rsv = ^ctrl.rsv;

  assign hit   = bus_valid && kind_ok && addr_ok && asid_ok && sz_ok && data_ok;
  assign defer = hit && bus_ifetch && ctrl.after;
  assign bef   = hit && bus_ifetch && !ctrl.after;
  assign imm   = hit && !defer;

endmodule

// File: rtl/brk_seq.sv
module brk_seq #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           seq_mode,
  input  logic           arm_clr,
  input  logic [NCH-1:0] ctrl_wr,
  input  logic           ret_valid,
  input  logic [NCH-1:0] imm,
  input  logic [NCH-1:0] defer,
  input  logic [NCH-1:0] bef,
  output logic           brk_req,
  output logic           brk_before,
  output logic           armed
);

  logic [NCH-1:0] pend_q, fire;
  logic           raise, raise_bef;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_pend
    assign fire[ch] = imm[ch] || (pend_q[ch] && ret_valid);
    always_ff @(posedge clk) begin
      if (rst)                          pend_q[ch] <= 1'b0;
      else if (defer[ch])               pend_q[ch] <= 1'b1;
      else if (ret_valid || ctrl_wr[ch]) pend_q[ch] <= 1'b0;
    end
  end

  assign raise     = seq_mode ? (fire[NCH-1] && armed) : (|fire);
  assign raise_bef = seq_mode ? (bef[NCH-1] && armed)  : (|bef);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed      <= 1'b0;
      brk_req    <= 1'b0;
      brk_before <= 1'b0;
    end else begin
      brk_req    <= raise;
      brk_before <= raise_bef;
      if (arm_clr || raise)       armed <= 1'b0;
      else if (seq_mode && fire[0]) armed <= 1'b1;
    end
  end

endmodule

// File: rtl/brk_unit.sv
module brk_unit
  import brk_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [RA_W-1:0]   cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              bus_valid,
  input  logic              bus_ifetch,
  input  logic              bus_write,
  input  logic [1:0]        bus_size,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_data,
  input  logic [ASID_W-1:0] bus_asid,
  input  logic              ret_valid,
  output logic              brk_req,
  output logic              brk_before,
  output logic              stat_a,
  output logic              stat_b
);

  logic [NCH-1:0][AW-1:0] cmp_addr, cmp_mask;
  brk_ctrl_t [NCH-1:0]    ctrl;
  logic [DW-1:0]          dval, dmask;
  logic                   seq_mode, arm_clr, armed;
  logic [NCH-1:0]         stat, ctrl_wr, hit, imm, defer, bef;

  brk_cfg_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .waddr(cfg_addr), .wdata(cfg_wdata),
    .hit(hit), .cmp_addr(cmp_addr), .cmp_mask(cmp_mask), .ctrl(ctrl),
    .dval(dval), .dmask(dmask), .seq_mode(seq_mode), .stat(stat),
    .ctrl_wr(ctrl_wr), .arm_clr(arm_clr)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    localparam bit LAST = (ch == NCH - 1);
    brk_channel #(.AW(AW), .DW(DW), .HAS_DATA(LAST)) u_ch (
      .bus_valid(bus_valid), .bus_ifetch(bus_ifetch), .bus_write(bus_write),
      .bus_size(bus_size), .bus_addr(bus_addr), .bus_data(bus_data),
      .bus_asid(bus_asid), .cmp_addr(cmp_addr[ch]), .cmp_mask(cmp_mask[ch]),
      .ctrl(ctrl[ch]), .dval(LAST ? dval : '0), .dmask(LAST ? dmask : '0),
      .hit(hit[ch]), .imm(imm[ch]), .defer(defer[ch]), .bef(bef[ch])
    );
  end

  brk_seq #(.NCH(NCH)) u_seq (
    .clk(clk), .rst(rst), .seq_mode(seq_mode), .arm_clr(arm_clr),
    .ctrl_wr(ctrl_wr), .ret_valid(ret_valid), .imm(imm), .defer(defer),
    .bef(bef), .brk_req(brk_req), .brk_before(brk_before), .armed(armed)
  );

  assign stat_a = stat[0];
  assign stat_b = stat[1];

endmodule

// File: rtl/brk_unit_chk.sv
module brk_unit_chk
  import brk_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                cfg_we,
  input logic [RA_W-1:0]     cfg_addr,
  input logic                brk_req,
  input logic                brk_before,
  input logic                stat_a,
  input logic                stat_b,
  input logic [NCH-1:0]      hit,
  input brk_ctrl_t [NCH-1:0] ctrl,
  input logic                armed,
  input logic                seq_mode
);

  a_r9_off_a_no_hit: assert property (@(posedge clk) disable iff (rst)
    !(ctrl[0].en_fetch || ctrl[0].en_data) |-> !hit[0]);

  a_r9_off_b_no_hit: assert property (@(posedge clk) disable iff (rst)
    !(ctrl[1].en_fetch || ctrl[1].en_data) |-> !hit[1]);

  a_r3_needs_arm: assert property (@(posedge clk) disable iff (rst)
    ($past(seq_mode) && brk_req) |-> $past(armed));

  a_r3_break_disarms: assert property (@(posedge clk) disable iff (rst)
    ($past(seq_mode) && brk_req) |-> !armed);

  a_r4_rewrite_disarms: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_we && (cfg_addr == RG_MODE || cfg_addr == RG_A_CTRL || cfg_addr == RG_B_CTRL))
      |-> !armed);

  a_r10_before_with_req: assert property (@(posedge clk) disable iff (rst)
    brk_before |-> brk_req);

  a_r11_sticky_a: assert property (@(posedge clk) disable iff (rst)
    $past(hit[0]) |-> stat_a);

  a_r11_sticky_b: assert property (@(posedge clk) disable iff (rst)
    $past(hit[1]) |-> stat_b);

  a_r12_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!brk_req && !stat_a && !stat_b && !armed));

endmodule

bind brk_unit brk_unit_chk u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .brk_req(brk_req), .brk_before(brk_before), .stat_a(stat_a), .stat_b(stat_b),
  .hit(hit), .ctrl(ctrl), .armed(armed), .seq_mode(seq_mode)
);

// File: tb/brk_unit_test.sv
`timescale 1ns/1ps
module brk_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        bus_valid = 1'b0, bus_ifetch = 1'b0, bus_write = 1'b0;
  logic [1:0]  bus_size = '0;
  logic [31:0] bus_addr = '0, bus_data = '0;
  logic [7:0]  bus_asid = '0;
  logic        ret_valid = 1'b0;
  logic        brk_req, brk_before, stat_a, stat_b;

  int nchk = 0;
  int nfail = 0;

  always #10 clk = ~clk;

  brk_unit uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .bus_valid(bus_valid), .bus_ifetch(bus_ifetch), .bus_write(bus_write),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_asid(bus_asid), .ret_valid(ret_valid),
    .brk_req(brk_req), .brk_before(brk_before), .stat_a(stat_a), .stat_b(stat_b)
  );

  typedef struct packed {
    logic        v, f, w;
    logic [1:0]  sz;
    logic [31:0] a, d;
    logic [7:0]  asid;
    logic        r, eb, ebf;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b1, 1'b0, 2'd1, 32'h8012, 32'hDEAD, 8'h11, 1'b0, 1'b1, 1'b1},
    '{1'b1, 1'b1, 1'b0, 2'd1, 32'h8018, 32'h0,    8'h22, 1'b0, 1'b0, 1'b0},
    '{1'b1, 1'b1, 1'b0, 2'd2, 32'h8016, 32'hFFFF, 8'h33, 1'b0, 1'b1, 1'b1},
    '{1'b1, 1'b1, 1'b0, 2'd1, 32'h8011, 32'h0,    8'h00, 1'b0, 1'b0, 1'b0},
    '{1'b1, 1'b1, 1'b0, 2'd1, 32'h0404, 32'h5,    8'h44, 1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b0, 1'b0, 2'd0, 32'h0,    32'h0,    8'h00, 1'b1, 1'b1, 1'b0},
    '{1'b0, 1'b0, 1'b0, 2'd0, 32'h0,    32'h0,    8'h00, 1'b1, 1'b0, 1'b0},
    '{1'b1, 1'b0, 1'b0, 2'd1, 32'h0404, 32'h0,    8'h00, 1'b0, 1'b0, 1'b0},
    '{1'b1, 1'b1, 1'b0, 2'd1, 32'h0405, 32'h0,    8'h00, 1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b1, 1'b0, 2'd1, 32'h8014, 32'h0,    8'h00, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic cfg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic step(input logic v, input logic f, input logic w, input logic [1:0] sz,
                      input logic [31:0] a, input logic [31:0] d, input logic [7:0] asid,
                      input logic r);
    @(negedge clk);
    bus_valid = v; bus_ifetch = f; bus_write = w; bus_size = sz;
    bus_addr = a; bus_data = d; bus_asid = asid; ret_valid = r;
    @(negedge clk);
    bus_valid = 1'b0; ret_valid = 1'b0;
  endtask

  task automatic fetch(input logic [31:0] a, input logic [7:0] asid, input logic [1:0] sz);
    step(1'b1, 1'b1, 1'b0, sz, a, 32'h0, asid, 1'b0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 reset brk_req", brk_req, 0);
    chk("R12 reset stat_a", stat_a, 0);
    chk("R12 reset stat_b", stat_b, 0);

    // R9: reset leaves both channels disabled although compare base 0 mask 0 would fit
    fetch(32'h0, 8'h0, 2'd0);
    chk("R9 disabled fetch brk", brk_req, 0);
    chk("R9 disabled fetch stat_a", stat_a, 0);
    step(1'b1, 1'b0, 1'b1, 2'd2, 32'h0, 32'h0, 8'h0, 1'b0);
    chk("R9 disabled data brk", brk_req, 0);

    // Independent mode: A after-exec fetch at 0x404; B before-exec fetch 0x8010 mask 6
    cfg(4'd0, 32'h0404); cfg(4'd1, 32'h0); cfg(4'd2, 32'h85);
    cfg(4'd3, 32'h8010); cfg(4'd4, 32'h6); cfg(4'd5, 32'h05);
    cfg(4'd8, 32'h6);
    for (int i = 0; i < NV; i++) begin
      step(VEC[i].v, VEC[i].f, VEC[i].w, VEC[i].sz, VEC[i].a, VEC[i].d, VEC[i].asid, VEC[i].r);
      chk($sformatf("R1 R2 R5 vec %0d brk_req", i), brk_req, VEC[i].eb);
      chk($sformatf("R5 vec %0d brk_before", i), brk_before, VEC[i].ebf);
    end
    chk("R11 stat_a sticky", stat_a, 1);
    chk("R11 stat_b sticky", stat_b, 1);
    cfg(4'd8, 32'h4);
    chk("R11 clear A keep B stat_a", stat_a, 0);
    chk("R11 clear A keep B stat_b", stat_b, 1);
    cfg(4'd8, 32'h0);
    chk("R11 clear B stat_b", stat_b, 0);

    // Sequence mode with ASID and word size
    cfg(4'd0, 32'h37226); cfg(4'd2, 32'h8000_0125);
    cfg(4'd3, 32'h3722E); cfg(4'd4, 32'h0); cfg(4'd5, 32'h7000_0125);
    cfg(4'd8, 32'h7);
    fetch(32'h3722E, 8'h70, 2'd1);
    chk("R3 B unarmed no break", brk_req, 0);
    fetch(32'h37226, 8'h81, 2'd1);
    chk("R6 A wrong ASID no break", brk_req, 0);
    fetch(32'h3722E, 8'h70, 2'd1);
    chk("R6 B after unmatched A no break", brk_req, 0);
    fetch(32'h37226, 8'h80, 2'd1);
    chk("R3 A alone no break", brk_req, 0);
    fetch(32'h3722E, 8'h70, 2'd2);
    chk("R7 B wrong size no break", brk_req, 0);
    fetch(32'h3722E, 8'h70, 2'd1);
    chk("R3 armed B breaks", brk_req, 1);
    chk("R5 armed B before flag", brk_before, 1);
    @(negedge clk);
    chk("R10 single-cycle pulse", brk_req, 0);
    fetch(32'h3722E, 8'h70, 2'd1);
    chk("R3 break disarms", brk_req, 0);
    fetch(32'h37226, 8'h80, 2'd1);
    cfg(4'd8, 32'h7);
    fetch(32'h3722E, 8'h70, 2'd1);
    chk("R4 mode rewrite disarms", brk_req, 0);
    fetch(32'h37226, 8'h80, 2'd1);
    cfg(4'd2, 32'h8000_0125);
    fetch(32'h3722E, 8'h70, 2'd1);
    chk("R4 ctrl rewrite disarms", brk_req, 0);
    fetch(32'h37226, 8'h80, 2'd1);
    fetch(32'h3722E, 8'h70, 2'd1);
    chk("R3 rearmed B breaks", brk_req, 1);

    // Channel B data compare, write cycles only
    cfg(4'd2, 32'h0);
    cfg(4'd3, 32'h100); cfg(4'd4, 32'hFF); cfg(4'd5, 32'h20A);
    cfg(4'd6, 32'h1234_0000); cfg(4'd7, 32'h0000_FFFF);
    cfg(4'd8, 32'h6);
    step(1'b1, 1'b0, 1'b1, 2'd2, 32'h1A0, 32'h1234_ABCD, 8'h0, 1'b0);
    chk("R8 data match breaks", brk_req, 1);
    chk("R8 data break not before", brk_before, 0);
    step(1'b1, 1'b0, 1'b1, 2'd2, 32'h1A0, 32'h1235_0000, 8'h0, 1'b0);
    chk("R8 data mismatch no break", brk_req, 0);
    step(1'b1, 1'b0, 1'b0, 2'd2, 32'h1A0, 32'h1234_0000, 8'h0, 1'b0);
    chk("R9 read filtered", brk_req, 0);
    step(1'b1, 1'b1, 1'b0, 2'd2, 32'h1A0, 32'h1234_0000, 8'h0, 1'b0);
    chk("R9 fetch filtered", brk_req, 0);
    step(1'b1, 1'b0, 1'b1, 2'd2, 32'h200, 32'h1234_0000, 8'h0, 1'b0);
    chk("R1 masked address mismatch", brk_req, 0);

    finish_run();
  end

endmodule